// File: doc/BRIEF.md
# Capacitive attenuator switch sequencer

This block sets the four gate enables of a step-down power stage whose input is taken from two capacitors stacked in series across the supply. The two capacitors split the supply in half, and the midpoint between them is called the center tap. Each clock cycle the block reads five inputs: the pulse-width on/off level for the current period, a center-tap comparator result (hysteresis is already applied to it), a flag that says the supply exceeds twice the output, and a request to bypass the attenuator during a load step. From these it chooses one switch pattern.

When the supply is high, each on-time is fed from one capacitor. Normally the top and bottom capacitors take turns from one period to the next. If the comparator reports that the capacitors have drifted apart, every on-time draws from the capacitor with the higher voltage until balance returns. When the supply is low, or when a bypass request is present, the high-side pair connects the stage straight to the full supply. Every change of switch pattern passes through a short window with all gates off, so that two switch pairs are never on together.

Top module: `att_switch_seq`

## Requirements
- R1: While reset is active and right after it, `gate_o` is 4'b1100 and `mode_o` is 1 (freewheel). The first half-supply on-time after reset uses the top capacitor.
- R2: Gate bit 0 drives SW1, bit 1 SW2, bit 2 SW3 and bit 3 SW4. With `pwm_on` low and no bypass request, the settled pattern is freewheel: `gate_o`=4'b1100, `mode_o`=1.
- R3: With `sup_high`=1, no imbalance and no bypass, successive on-times alternate between top (`gate_o`=4'b1001, `mode_o`=2) and bottom (`gate_o`=4'b0110, `mode_o`=3), starting with top.
- R4: If `tap_unbal`=1 at the start of an on-time, that on-time uses top when `tap_top_high`=1 and bottom otherwise. After balance returns, the next on-time uses the capacitor opposite to the one used last.
- R5: The comparator inputs are read only in the cycle where `pwm_on` rises. A change on them later in the same pulse does not change the capacitor in use.
- R6: With `sup_high`=0 and no bypass, an on-time gives `gate_o`=4'b0011 and `mode_o`=4. Such an on-time does not advance the top/bottom alternation.
- R7: `bypass_req`=1 gives `gate_o`=4'b0011 and `mode_o`=5 whatever the state of `pwm_on`. An on-time that starts during a bypass does not advance the alternation.
- R8: Every change of `mode_o` between two non-zero codes passes through `mode_o`=0 with `gate_o`=4'b0000 for `BLANK_CYCLES` cycles. A new input pattern shows on the outputs one clock after it is sampled, or `BLANK_CYCLES`+1 clocks after it when a blank is needed.
- R9: `gate_o` never goes from one non-zero pattern to a different non-zero pattern in consecutive cycles. SW1 is never on together with SW3, and SW2 is never on together with SW4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_on | input | 1 | On-time level of the current switching period |
| tap_unbal | input | 1 | Comparator reports a significant center-tap imbalance |
| tap_top_high | input | 1 | Top capacitor holds the higher voltage (used only when `tap_unbal` is 1) |
| sup_high | input | 1 | Supply exceeds twice the output; selects half-supply operation |
| bypass_req | input | 1 | Load-transient request to feed the full supply |
| gate_o | output | 4 | Gate enables, bit 0 = SW1 up to bit 3 = SW4 |
| mode_o | output | 3 | Current pattern: 0 blank, 1 freewheel, 2 top, 3 bottom, 4 full supply, 5 bypass |

## Verification
A wrong choice of capacitor inside the block shows on `gate_o` and `mode_o` within one blanking window of the next `pwm_on` rise. Stuck alternation state would therefore show as two top or two bottom on-times in a row while the comparator reports balance. A corrupt blanking counter shows at the very next pattern change, either as a direct jump between two non-zero patterns or as a blank that lasts too long. Because the capacitor choice is latched only at pulse starts, comparator activity in the middle of a pulse is applied on purpose. This exposes any design that samples continuously.

// File: rtl/att_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the attenuator switch sequencer.
// The mode codes are visible on the status port, so their values are fixed.
package att_seq_pkg;

    localparam int NUM_GATES = 4;

    typedef enum logic [2:0] {
        MD_BLANK = 3'd0,
        MD_FREE  = 3'd1,
        MD_TOP   = 3'd2,
        MD_BOT   = 3'd3,
        MD_FULL  = 3'd4,
        MD_BYP   = 3'd5
    } mode_e;

    // Switch pattern of each mode; bit 0 = SW1 ... bit 3 = SW4.
    function automatic logic [NUM_GATES-1:0] gates_of(input mode_e m);
        case (m)
            MD_FREE:        return 4'b1100;
            MD_TOP:         return 4'b1001;
            MD_BOT:         return 4'b0110;
            MD_FULL,
            MD_BYP:         return 4'b0011;
            default:        return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/att_cap_picker.sv
`timescale 1ns/1ps
// Chooses which capacitor feeds the half-supply on-time.
// Assumes: pwm_on holds a level for each period, and the comparator inputs
// already carry hysteresis. The choice is latched only at the rise of pwm_on,
// and only when that on-time is really a half-supply one (no bypass).
module att_cap_picker (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_on,
    input  logic sup_high,
    input  logic bypass_req,
    input  logic tap_unbal,
    input  logic tap_top_high,
    output logic use_bot
);
    logic pwm_q;
    logic sel_bot;
    logic next_bot;
    logic rise;
    logic pick_bot;
    logic latch_en;

    // Pulse start detection and the capacitor the current pulse should use.
    always_comb begin
        rise     = pwm_on & ~pwm_q;
        pick_bot = tap_unbal ? ~tap_top_high : next_bot;
        latch_en = rise & sup_high & ~bypass_req;
        use_bot  = rise ? pick_bot : sel_bot;
    end

    // Hold the choice for the pulse and move the alternation to the other capacitor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q    <= 1'b0;
            sel_bot  <= 1'b0;
            next_bot <= 1'b0;
        end else begin
            pwm_q <= pwm_on;
            if (latch_en) begin
                sel_bot  <= pick_bot;
                next_bot <= ~pick_bot;
            end
        end
    end

endmodule

// File: rtl/att_mode_arbiter.sv
`timescale 1ns/1ps
// Works out the wanted switch mode from the present inputs.
// Priority: bypass, then on-time (full or half supply), then freewheel.
// Never asks for the blank mode; that is added by the blanking sequencer.
module att_mode_arbiter
    import att_seq_pkg::*;
(
    input  logic  pwm_on,
    input  logic  sup_high,
    input  logic  bypass_req,
    input  logic  use_bot,
    output mode_e want
);
    // Priority selection of the wanted mode.
    always_comb begin
        if (bypass_req)
            want = MD_BYP;
        else if (!pwm_on)
            want = MD_FREE;
        else if (!sup_high)
            want = MD_FULL;
        else if (use_bot)
            want = MD_BOT;
        else
            want = MD_TOP;
    end

endmodule

// File: rtl/att_blank_seq.sv
`timescale 1ns/1ps
// Holds the applied mode. On any change it inserts BLANK_CYCLES cycles with
// every gate off, then takes whatever mode is wanted at the end of the blank.
// Assumes BLANK_CYCLES >= 1 and that want is never the blank mode.
module att_blank_seq
    import att_seq_pkg::*;
#(
    parameter int BLANK_CYCLES = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e want,
    output mode_e cur
);
    localparam int CW = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(BLANK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Mode register with the blanking countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= MD_FREE;
            cnt <= '0;
        end else if (cur == MD_BLANK) begin
            if (cnt == '0)
                cur <= want;
            else
                cnt <= cnt - 1'b1;
        end else if (want != cur) begin
            cur <= MD_BLANK;
            cnt <= CNT_LOAD;
        end
    end

endmodule

// File: rtl/att_gate_decode.sv
`timescale 1ns/1ps
// Turns the applied mode into one enable per switch.
// Assumes mode comes straight from a register, so the gates change only at clock edges.
module att_gate_decode
    import att_seq_pkg::*;
(
    input  mode_e                 mode,
    output logic [NUM_GATES-1:0]  gate
);
    logic [NUM_GATES-1:0] pattern;

    // Look up the switch pattern of the mode.
    always_comb pattern = gates_of(mode);

    // One driver per switch enable.
    for (genvar i = 0; i < NUM_GATES; i++) begin : g_sw
        assign gate[i] = pattern[i];
    end

endmodule

// File: rtl/att_switch_seq.sv
`timescale 1ns/1ps
// Top level of the attenuator switch sequencer.
// Assumes synchronous inputs. The outputs are the registered mode and its
// decoded gates; dead time inside a switch pair is handled outside this block.
module att_switch_seq
    import att_seq_pkg::*;
#(
    parameter int BLANK_CYCLES = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwm_on,
    input  logic                 tap_unbal,
    input  logic                 tap_top_high,
    input  logic                 sup_high,
    input  logic                 bypass_req,
    output logic [NUM_GATES-1:0] gate_o,
    output logic [2:0]           mode_o
);
    logic  use_bot;
    mode_e want;
    mode_e cur;

    att_cap_picker u_pick (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_on       (pwm_on),
        .sup_high     (sup_high),
        .bypass_req   (bypass_req),
        .tap_unbal    (tap_unbal),
        .tap_top_high (tap_top_high),
        .use_bot      (use_bot)
    );

    att_mode_arbiter u_arb (
        .pwm_on     (pwm_on),
        .sup_high   (sup_high),
        .bypass_req (bypass_req),
        .use_bot    (use_bot),
        .want       (want)
    );

    att_blank_seq #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .cur   (cur)
    );

    att_gate_decode u_dec (
        .mode (cur),
        .gate (gate_o)
    );

    // Status output is the raw mode code.
    always_comb mode_o = cur;

endmodule

// File: rtl/att_switch_seq_chk.sv
`timescale 1ns/1ps
// Port-level properties of the sequencer, attached by bind.
module att_switch_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_on,
    input logic       sup_high,
    input logic       bypass_req,
    input logic [3:0] gate_o,
    input logic [2:0] mode_o
);
    // No direct hop between two different active modes.
    assert_blank_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 3'd0 && $past(mode_o) != 3'd0) |-> mode_o == $past(mode_o));

    // Gates never jump from one active pattern to another.
    assert_no_hop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != 4'b0000 && $past(gate_o) != 4'b0000) |-> gate_o == $past(gate_o));

    // Neither leg is ever shorted.
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[2]) && !(gate_o[1] && gate_o[3]));

    // Bypass request leads to bypass or blank.
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_req |=> (mode_o == 3'd5 || mode_o == 3'd0));

    // Off-time leads to freewheel or blank.
    assert_freewheel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_on && !bypass_req) |=> (mode_o == 3'd1 || mode_o == 3'd0));

    // Low supply on-time leads to full-supply or blank.
    assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_on && !sup_high && !bypass_req) |=> (mode_o == 3'd4 || mode_o == 3'd0));

    // A running top pulse keeps its capacitor.
    assert_hold_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && pwm_on && $past(pwm_on) && sup_high && !bypass_req)
        |=> mode_o == 3'd2);

    // A running bottom pulse keeps its capacitor.
    assert_hold_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && pwm_on && $past(pwm_on) && sup_high && !bypass_req)
        |=> mode_o == 3'd3);

endmodule

bind att_switch_seq att_switch_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_on     (pwm_on),
    .sup_high   (sup_high),
    .bypass_req (bypass_req),
    .gate_o     (gate_o),
    .mode_o     (mode_o)
);

// File: tb/att_switch_seq_tb_top.sv
`timescale 1ns/1ps
module att_switch_seq_tb_top;
    localparam int BLANK_CYCLES = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_on = 1'b0;
    logic tap_unbal = 1'b0;
    logic tap_top_high = 1'b0;
    logic sup_high = 1'b1;
    logic bypass_req = 1'b0;
    logic [3:0] gate_o;
    logic [2:0] mode_o;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    logic [2:0] m_mode;
    int         m_cnt;
    logic       m_pwmq, m_sel_bot, m_next_bot;

    always #2.5 clk = ~clk;

    att_switch_seq #(.BLANK_CYCLES(BLANK_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_on(pwm_on), .tap_unbal(tap_unbal),
        .tap_top_high(tap_top_high), .sup_high(sup_high), .bypass_req(bypass_req),
        .gate_o(gate_o), .mode_o(mode_o)
    );

    function automatic logic [3:0] exp_gates(input logic [2:0] m);
        case (m)
            3'd1: return 4'b1100;
            3'd2: return 4'b1001;
            3'd3: return 4'b0110;
            3'd4, 3'd5: return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R8";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3 or R4";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 3'd1; m_cnt = 0; m_pwmq = 1'b0; m_sel_bot = 1'b0; m_next_bot = 1'b0;
    endtask

    // One clock of the expected behaviour, using the inputs held across the edge.
    task automatic model_step();
        logic rise, pick_bot, use_bot;
        logic [2:0] want;
        rise     = pwm_on && !m_pwmq;
        pick_bot = tap_unbal ? !tap_top_high : m_next_bot;
        use_bot  = rise ? pick_bot : m_sel_bot;
        if (bypass_req)     want = 3'd5;
        else if (!pwm_on)   want = 3'd1;
        else if (!sup_high) want = 3'd4;
        else                want = use_bot ? 3'd3 : 3'd2;
        if (m_mode == 3'd0) begin
            if (m_cnt == 0) m_mode = want; else m_cnt--;
        end else if (want != m_mode) begin
            m_mode = 3'd0; m_cnt = BLANK_CYCLES - 1;
        end
        if (rise && sup_high && !bypass_req) begin
            m_sel_bot = pick_bot; m_next_bot = !pick_bot;
        end
        m_pwmq = pwm_on;
    endtask

    task automatic compare_model();
        vectors++;
        if (gate_o !== exp_gates(m_mode) || mode_o !== m_mode) begin
            errors++;
            $display("FAIL %s: gate=%b mode=%0d expected gate=%b mode=%0d",
                     req_of(m_mode), gate_o, mode_o, exp_gates(m_mode), m_mode);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            model_step();
            compare_model();
        end
    endtask

    task automatic expect_now(input logic [3:0] g, input logic [2:0] m, input string tag);
        vectors++;
        if (gate_o !== g || mode_o !== m) begin
            errors++;
            $display("FAIL %s: gate=%b mode=%0d expected gate=%b mode=%0d",
                     tag, gate_o, mode_o, g, m);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    // Watchdog: a hung run is reported as a miscompare.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): run did not end, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_now(4'b1100, 3'd1, "R1 during reset");
        rst_n = 1'b1;
        step(1);
        expect_now(4'b1100, 3'd1, "R1 after reset");

        // First on-time: blank, then top (R8, R3).
        pwm_on = 1'b1;
        step(1); expect_now(4'b0000, 3'd0, "R8 blank");
        step(1); expect_now(4'b1001, 3'd2, "R3 first top");
        // Comparator flips mid-pulse: capacitor unchanged (R5).
        tap_unbal = 1'b1; tap_top_high = 1'b0;
        step(2); expect_now(4'b1001, 3'd2, "R5 mid-pulse");
        pwm_on = 1'b0; tap_unbal = 1'b0;
        step(2); expect_now(4'b1100, 3'd1, "R2 freewheel");
        pwm_on = 1'b1;
        step(2); expect_now(4'b0110, 3'd3, "R3 alternate bottom");

        // Imbalance: top higher twice, then resume alternation (R4).
        pwm_on = 1'b0; step(2);
        tap_unbal = 1'b1; tap_top_high = 1'b1;
        pwm_on = 1'b1; step(2); expect_now(4'b1001, 3'd2, "R4 top high");
        pwm_on = 1'b0; step(2);
        pwm_on = 1'b1; step(2); expect_now(4'b1001, 3'd2, "R4 top high again");
        pwm_on = 1'b0; tap_unbal = 1'b0; step(2);
        pwm_on = 1'b1; step(2); expect_now(4'b0110, 3'd3, "R4 resume opposite");

        // Low supply: full-supply on-time (R6).
        pwm_on = 1'b0; step(2);
        sup_high = 1'b0;
        pwm_on = 1'b1; step(2); expect_now(4'b0011, 3'd4, "R6 full supply");
        pwm_on = 1'b0; step(2);

        // Bypass regardless of pwm (R7), alternation not advanced (R6, R7).
        bypass_req = 1'b1;
        step(2); expect_now(4'b0011, 3'd5, "R7 bypass");
        sup_high = 1'b1; pwm_on = 1'b1;
        step(2); expect_now(4'b0011, 3'd5, "R7 bypass during on-time");
        pwm_on = 1'b0; bypass_req = 1'b0;
        step(2); expect_now(4'b1100, 3'd1, "R2 freewheel after bypass");
        pwm_on = 1'b1;
        step(2); expect_now(4'b1001, 3'd2, "R7 alternation held");
        pwm_on = 1'b0; step(2);

        // Random periods with mid-pulse disturbances.
        for (int p = 0; p < 1500; p++) begin
            int len = 4 + int'($urandom % 14);
            int on  = int'($urandom % (len + 1));
            sup_high  = ($urandom % 8) != 0;
            tap_unbal = ($urandom % 3) == 0;
            tap_top_high = $urandom % 2;
            for (int c = 0; c < len; c++) begin
                pwm_on = (c < on);
                if ($urandom % 20 == 0) bypass_req = ~bypass_req;
                if ($urandom % 6 == 0) tap_unbal = ~tap_unbal;
                if ($urandom % 6 == 0) tap_top_high = ~tap_top_high;
                step(1);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule